// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind the serial protocol engine of a small non-volatile memory. During a write transaction it collects the received data bytes into a page RAM of a few entries. When the transaction closes with STOP, it runs a self-timed program cycle that moves the buffered bytes into the memory array, one byte per millisecond tick. The program cycle therefore takes N ticks for N buffered bytes.

For every data byte it returns an accept or reject decision, and the protocol engine turns that decision into ACK or NACK. A busy flag tells the engine to stay silent while programming is in progress. A parameter selects what happens when more bytes arrive than the page holds. In wrap mode the write position circles round the page and later bytes overwrite earlier ones. In reject mode the extra byte is refused and the whole write is dropped. A second parameter enables a protect input that guards the upper half of the array.

Top module: `page_prog_seq`

## Requirements
- R1: After reset `busy`, `arr_we` and `ack_vld` are all 0.
- R2: When idle and not aborted, every accepted data byte produces `ack_vld`=1 with `ack_ok`=1 in the cycle after `byte_vld`. The byte is stored in the next page slot, and slots fill from index 0.
- R3: Byte k of a page write (k counted from 0) goes to an array address whose upper bits equal the loaded start address. Its low log2(PAGE_BYTES) bits are the start address's low bits plus k, modulo PAGE_BYTES. In wrap mode (`OVF_POL`=wrap), byte PAGE_BYTES+j is accepted and replaces the content of slot j.
- R4: In reject mode, a data byte arriving when the page already holds PAGE_BYTES bytes is answered with `ack_ok`=0. That byte and all later bytes of the transaction are refused, and the following STOP starts no program cycle.
- R5: A STOP seen while idle, with at least one accepted byte and no abort, raises `busy` at the next clock edge.
- R6: While busy, each `ms_tick` causes exactly one single-cycle `arr_we` on the next edge, with slots written in index order. After N ticks for N buffered bytes, `busy` falls on the same edge as the last write.
- R7: With `WP_EN`=1, `wp_in`=1 and start address MSB=1, the first data byte gets `ack_ok`=0 and so do all later bytes. No program cycle follows.
- R8: With `WP_EN`=0, `wp_in` has no effect: upper-half writes are accepted and programmed.
- R9: A STOP with no accepted byte, or after an abort, leaves `busy` at 0 and writes nothing. A START or an address load discards any pending bytes.
- R10: While busy, data bytes get `ack_ok`=0 and are not stored. Address loads, START and STOP are ignored and do not change the bytes being programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Strobe: latch `start_addr` and open a new page |
| start_addr | input | ADDR_W | Write start address |
| byte_vld | input | 1 | Strobe: one data byte on `byte_data` |
| byte_data | input | DATA_W | Received data byte |
| start_evt | input | 1 | START or repeated START seen on the bus |
| stop_evt | input | 1 | STOP seen on the bus |
| wp_in | input | 1 | Write-protect level for the upper half |
| ms_tick | input | 1 | One-cycle millisecond tick |
| ack_vld | output | 1 | Decision valid for the previous data byte |
| ack_ok | output | 1 | 1 = accept (ACK), 0 = reject (NACK) |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write strobe, one cycle per byte |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The assertions rely on two properties of the inputs. First, the four event strobes (address load, data byte, START, STOP) are never asserted in the same cycle. Second, `ms_tick` pulses are never on adjacent cycles. The bench drives each strobe as an isolated one-cycle pulse at the falling edge, with idle cycles between pulses. Ticks are spaced four cycles apart. Three instances run side by side on the same stimulus: wrap with an 8-byte page, reject with a 2-byte page, and reject with protection disabled. The sweep covers byte counts from 0 to 10, start addresses at page edges in both halves of the array, and both protect levels.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    typedef enum logic {
        POL_REJECT = 1'b0,
        POL_WRAP   = 1'b1
    } ovf_pol_e;

    function automatic logic wp_blocks(input logic wp_enable, input logic wp_level,
                                       input logic addr_msb);
        return wp_enable & wp_level & addr_msb;
    endfunction

endpackage

// File: rtl/ppb_buffer.sv
module ppb_buffer #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_d [PAGE_BYTES];
    logic [DATA_W-1:0] slot_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/ppb_addr_gen.sv
module ppb_addr_gen #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  slot_idx,
    output logic [ADDR_W-1:0] slot_addr
);

    logic [IDX_W-1:0] low_bits;

    always_comb begin
        low_bits  = base_addr[IDX_W-1:0] + slot_idx;
        slot_addr = {base_addr[ADDR_W-1:IDX_W], low_bits};
    end

endmodule

// File: rtl/ppb_ctrl.sv
module ppb_ctrl
    import ppb_pkg::*;
#(
    parameter int       ADDR_W     = 8,
    parameter int       PAGE_BYTES = 8,
    parameter ovf_pol_e OVF_POL    = POL_WRAP,
    parameter bit       WP_EN      = 1'b1,
    localparam int      IDX_W      = $clog2(PAGE_BYTES),
    localparam int      CNT_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              wp_in,
    input  logic              ms_tick,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic              busy,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              prog_issue,
    output logic [IDX_W-1:0]  prog_idx,
    output logic [ADDR_W-1:0] base_addr
);

    localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        logic              busy;
        logic              abort;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  wr_idx;
        logic [IDX_W-1:0]  prog_idx;
        logic [ADDR_W-1:0] base;
        logic              ack_vld;
        logic              ack_ok;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;
    logic  page_full;
    logic  wp_hit;
    logic  last_slot;
    logic  store_en;

    always_comb begin
        page_full = (ctl_q.cnt == PAGE_CNT);
        wp_hit    = wp_blocks(WP_EN, wp_in, ctl_q.base[ADDR_W-1]);
        last_slot = ((CNT_W'(ctl_q.prog_idx) + CNT_W'(1)) == ctl_q.cnt);
        store_en  = 1'b0;

        ctl_d         = ctl_q;
        ctl_d.ack_vld = 1'b0;
        ctl_d.ack_ok  = 1'b0;

        if (ctl_q.busy) begin
            if (ms_tick) begin
                ctl_d.prog_idx = ctl_q.prog_idx + IDX_W'(1);
                if (last_slot) begin
                    ctl_d.busy     = 1'b0;
                    ctl_d.cnt      = '0;
                    ctl_d.wr_idx   = '0;
                    ctl_d.prog_idx = '0;
                end
            end
            if (byte_vld) begin
                ctl_d.ack_vld = 1'b1;
            end
        end else if (addr_load) begin
            ctl_d.base   = start_addr;
            ctl_d.cnt    = '0;
            ctl_d.wr_idx = '0;
            ctl_d.abort  = 1'b0;
        end else if (start_evt) begin
            ctl_d.cnt    = '0;
            ctl_d.wr_idx = '0;
            ctl_d.abort  = 1'b0;
        end else if (stop_evt) begin
            if ((ctl_q.cnt != '0) && !ctl_q.abort) begin
                ctl_d.busy     = 1'b1;
                ctl_d.prog_idx = '0;
            end else begin
                ctl_d.cnt    = '0;
                ctl_d.wr_idx = '0;
                ctl_d.abort  = 1'b0;
            end
        end else if (byte_vld) begin
            ctl_d.ack_vld = 1'b1;
            if (ctl_q.abort) begin
                ctl_d.ack_ok = 1'b0;
            end else if (wp_hit) begin
                ctl_d.abort = 1'b1;
            end else if (page_full && (OVF_POL == POL_REJECT)) begin
                ctl_d.abort = 1'b1;
            end else begin
                ctl_d.ack_ok = 1'b1;
                store_en     = 1'b1;
                ctl_d.wr_idx = ctl_q.wr_idx + IDX_W'(1);
                if (!page_full) begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ack_vld    = ctl_q.ack_vld;
    assign ack_ok     = ctl_q.ack_ok;
    assign busy       = ctl_q.busy;
    assign buf_we     = store_en;
    assign buf_idx    = ctl_q.wr_idx;
    assign prog_issue = ctl_q.busy & ms_tick;
    assign prog_idx   = ctl_q.prog_idx;
    assign base_addr  = ctl_q.base;

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= PAGE_CNT)
        else $error("page count beyond page size");

    p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.busy) |-> $past(stop_evt))
        else $error("busy rose without STOP");

    p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ack_vld && $past(ctl_q.busy)) |-> !ctl_q.ack_ok)
        else $error("byte accepted while programming");

    p_wp_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ack_vld && ctl_q.ack_ok) |->
            !(WP_EN && $past(wp_in) && $past(ctl_q.base[ADDR_W-1])))
        else $error("protected byte accepted");

    p_evt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_load, byte_vld, start_evt, stop_evt}))
        else $error("event strobes overlap");

endmodule

// File: rtl/ppb_wport.sv
module ppb_wport #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wport_s;

    wport_s wp_d, wp_q;

    always_comb begin
        wp_d    = wp_q;
        wp_d.we = issue;
        if (issue) begin
            wp_d.addr = addr_in;
            wp_d.data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
        end else begin
            wp_q <= wp_d;
        end
    end

    assign we   = wp_q.we;
    assign addr = wp_q.addr;
    assign data = wp_q.data;

    p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wp_q.we |=> !wp_q.we)
        else $error("array write longer than one cycle");

endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
    import ppb_pkg::*;
#(
    parameter int       ADDR_W     = 8,
    parameter int       DATA_W     = 8,
    parameter int       PAGE_BYTES = 8,
    parameter ovf_pol_e OVF_POL    = POL_WRAP,
    parameter bit       WP_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              wp_in,
    input  logic              ms_tick,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam int IDX_W = $clog2(PAGE_BYTES);

    logic              buf_we;
    logic [IDX_W-1:0]  buf_idx;
    logic              prog_issue;
    logic [IDX_W-1:0]  prog_idx;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] slot_addr;
    logic [DATA_W-1:0] slot_data;

    ppb_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .OVF_POL    (OVF_POL),
        .WP_EN      (WP_EN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .start_addr (start_addr),
        .byte_vld   (byte_vld),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .wp_in      (wp_in),
        .ms_tick    (ms_tick),
        .ack_vld    (ack_vld),
        .ack_ok     (ack_ok),
        .busy       (busy),
        .buf_we     (buf_we),
        .buf_idx    (buf_idx),
        .prog_issue (prog_issue),
        .prog_idx   (prog_idx),
        .base_addr  (base_addr)
    );

    ppb_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (buf_idx),
        .wr_data (byte_data),
        .rd_idx  (prog_idx),
        .rd_data (slot_data)
    );

    ppb_addr_gen #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_agen (
        .base_addr (base_addr),
        .slot_idx  (prog_idx),
        .slot_addr (slot_addr)
    );

    ppb_wport #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wport (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (prog_issue),
        .addr_in (slot_addr),
        .data_in (slot_data),
        .we      (arr_we),
        .addr    (arr_addr),
        .data    (arr_wdata)
    );

    p_last_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> arr_we)
        else $error("busy fell without final array write");

endmodule

// File: tb/sim_page_prog_seq.sv
module sim_page_prog_seq;
    import ppb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NDUT = 3;
    localparam int PB   [NDUT] = '{8, 2, 2};
    localparam bit WRAP [NDUT] = '{1'b1, 1'b0, 1'b0};
    localparam bit WPE  [NDUT] = '{1'b1, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_load = 1'b0, byte_vld = 1'b0, start_evt = 1'b0, stop_evt = 1'b0;
    logic wp_in = 1'b0, ms_tick = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0] byte_data = '0;

    logic ackv [NDUT];
    logic acko [NDUT];
    logic bsy  [NDUT];
    logic we   [NDUT];
    logic [AW-1:0] waddr [NDUT];
    logic [7:0]    wdata [NDUT];

    logic [7:0] got_mem [NDUT][256];
    logic [7:0] exp_mem [NDUT][256];
    logic       ack_got [NDUT][16];
    int n_ack [NDUT];
    int n_wr  [NDUT];
    int n_tk  [NDUT];
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_prog_seq #(.ADDR_W(AW), .PAGE_BYTES(8), .OVF_POL(POL_WRAP), .WP_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .start_evt(start_evt),
        .stop_evt(stop_evt), .wp_in(wp_in), .ms_tick(ms_tick), .ack_vld(ackv[0]),
        .ack_ok(acko[0]), .busy(bsy[0]), .arr_we(we[0]), .arr_addr(waddr[0]),
        .arr_wdata(wdata[0]));

    page_prog_seq #(.ADDR_W(AW), .PAGE_BYTES(2), .OVF_POL(POL_REJECT), .WP_EN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .start_evt(start_evt),
        .stop_evt(stop_evt), .wp_in(wp_in), .ms_tick(ms_tick), .ack_vld(ackv[1]),
        .ack_ok(acko[1]), .busy(bsy[1]), .arr_we(we[1]), .arr_addr(waddr[1]),
        .arr_wdata(wdata[1]));

    page_prog_seq #(.ADDR_W(AW), .PAGE_BYTES(2), .OVF_POL(POL_REJECT), .WP_EN(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .start_evt(start_evt),
        .stop_evt(stop_evt), .wp_in(wp_in), .ms_tick(ms_tick), .ack_vld(ackv[2]),
        .ack_ok(acko[2]), .busy(bsy[2]), .arr_we(we[2]), .arr_addr(waddr[2]),
        .arr_wdata(wdata[2]));

    always @(negedge clk) begin
        for (int i = 0; i < NDUT; i++) begin
            if (we[i]) begin
                got_mem[i][waddr[i]] = wdata[i];
                n_wr[i]++;
            end
            if (ackv[i] && n_ack[i] < 16) begin
                ack_got[i][n_ack[i]] = acko[i];
                n_ack[i]++;
            end
            if (ms_tick && bsy[i]) n_tk[i]++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int dut, input int act,
                       input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s dut%0d actual=%0d expected=%0d", tag, dut, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic logic [7:0] dat(input int seed, input int k);
        return 8'((seed * 7 + k * 13 + 1) & 255);
    endfunction

    task automatic pulse_load(input logic [AW-1:0] a);
        @(negedge clk); start_addr = a; addr_load = 1'b1;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic pulse_byte(input logic [7:0] d);
        @(negedge clk); byte_data = d; byte_vld = 1'b1;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int t = 0; t < n; t++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // One write transaction on all instances with per-instance expectations
    task automatic tx(input logic [AW-1:0] base, input int n, input bit wp,
                      input int seed, input bit poke);
        bit         exp_prog [NDUT];
        int         exp_n    [NDUT];
        bit         exp_ok   [NDUT][16];
        logic [7:0] sd       [NDUT][8];
        string      atag     [NDUT];
        for (int i = 0; i < NDUT; i++) begin
            bit wpb;
            bit ab;
            int acc;
            wpb = WPE[i] && wp && base[AW-1];
            ab = wpb;
            acc = 0;
            for (int k = 0; k < n; k++) begin
                bit ok;
                ok = !ab && (WRAP[i] || k < PB[i]);
                if (!ok) ab = 1'b1;
                exp_ok[i][k] = ok;
                if (ok) begin
                    sd[i][k % PB[i]] = dat(seed, k);
                    acc++;
                end
            end
            exp_prog[i] = (acc > 0) && !ab;
            exp_n[i] = exp_prog[i] ? ((acc < PB[i]) ? acc : PB[i]) : 0;
            if (wpb) atag[i] = "R7";
            else if (!WPE[i] && wp && base[AW-1]) atag[i] = "R8";
            else if (n > PB[i]) atag[i] = WRAP[i] ? "R3" : "R4";
            else atag[i] = "R2";
            n_ack[i] = 0; n_wr[i] = 0; n_tk[i] = 0;
        end
        wp_in = wp;
        pulse_load(base);
        for (int k = 0; k < n; k++) begin
            pulse_byte(dat(seed, k));
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        for (int i = 0; i < NDUT; i++) begin
            int bad;
            bad = 0;
            for (int k = 0; k < n; k++) if (ack_got[i][k] !== exp_ok[i][k]) bad++;
            chk(n_ack[i] == n, atag[i], i, n_ack[i], n);
            chk(bad == 0, atag[i], i, bad, 0);
        end
        pulse_stop();
        for (int i = 0; i < NDUT; i++)
            chk(bsy[i] === exp_prog[i], exp_prog[i] ? "R5" : "R9", i, bsy[i], exp_prog[i]);
        if (poke) begin
            // R10: traffic during the program cycle must be refused or ignored
            pulse_byte(8'hEE);
            @(negedge clk);
            pulse_load(8'h40);
            pulse_stop();
            for (int i = 0; i < NDUT; i++)
                if (exp_prog[i])
                    chk(n_ack[i] == n + 1 && ack_got[i][n] == 1'b0, "R10", i,
                        ack_got[i][n], 0);
        end
        run_ticks(12);
        for (int i = 0; i < NDUT; i++) begin
            int bad;
            bad = 0;
            chk(bsy[i] == 1'b0, "R6", i, bsy[i], 0);
            chk(n_wr[i] == exp_n[i], "R6", i, n_wr[i], exp_n[i]);
            chk(n_tk[i] == exp_n[i], "R6", i, n_tk[i], exp_n[i]);
            for (int s = 0; s < exp_n[i]; s++) begin
                logic [AW-1:0] a;
                a = (base & ~AW'(PB[i] - 1)) | ((base + AW'(s)) & AW'(PB[i] - 1));
                exp_mem[i][a] = sd[i][s];
            end
            for (int a = 0; a < 256; a++) if (got_mem[i][a] !== exp_mem[i][a]) bad++;
            chk(bad == 0, (n > PB[i] && WRAP[i]) ? "R3" : "R6", i, bad, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [AW-1:0] bases [6];
        int seed;
        bases = '{8'h00, 8'h05, 8'h0E, 8'h7F, 8'hF3, 8'hFF};
        seed = 1;
        for (int i = 0; i < NDUT; i++) begin
            n_ack[i] = 0; n_wr[i] = 0; n_tk[i] = 0;
            for (int a = 0; a < 256; a++) begin
                got_mem[i][a] = 8'h00;
                exp_mem[i][a] = 8'h00;
            end
        end
        repeat (3) @(negedge clk);
        for (int i = 0; i < NDUT; i++) begin
            chk(bsy[i] === 1'b0, "R1", i, bsy[i], 0);
            chk(we[i] === 1'b0, "R1", i, we[i], 0);
            chk(ackv[i] === 1'b0, "R1", i, ackv[i], 0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int b = 0; b < 6; b++)
            for (int w = 0; w < 2; w++)
                for (int n = 0; n <= 10; n++) begin
                    tx(bases[b], n, w[0], seed, 1'b0);
                    seed++;
                end

        // R10: activity during programming
        tx(8'h10, 2, 1'b0, 77, 1'b1);

        // R9: START discards pending bytes, later STOP programs nothing
        for (int i = 0; i < NDUT; i++) begin n_wr[i] = 0; n_tk[i] = 0; end
        pulse_load(8'h20);
        pulse_byte(8'h5A);
        @(negedge clk);
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
        pulse_stop();
        for (int i = 0; i < NDUT; i++) chk(bsy[i] === 1'b0, "R9", i, bsy[i], 0);
        run_ticks(3);
        for (int i = 0; i < NDUT; i++) chk(n_wr[i] == 0, "R9", i, n_wr[i], 0);

        finish_run();
    end

endmodule